// File: doc/BRIEF.md
# H-Bridge Gate Control with Overcurrent Retry

This block is the digital control core of a single H-bridge motor driver. It turns two control inputs into four registered gate enables: a high-side and a low-side switch on each of the two output legs. A leg whose two switches are both off floats. A leg whose high-side switch is on drives high, and a leg whose low-side switch is on drives low. A build-time parameter picks how the two control inputs are read. In the two-input style each input commands one leg. In the direction/enable style one input sets the current direction and the other enables the bridge.

On top of the drive mapping sit three shutdown sources. An active-low sleep input forces coast. An undervoltage flag turns every switch off for as long as it is asserted. Four per-switch overcurrent flags feed a fault state machine (run, deglitch, retry wait). A flag that persists past a deglitch window shuts the bridge down for a fixed retry interval, and the bridge then restarts without outside help. All of these conditions arrive as synchronous digital flags. The block has no data stream, so it has no valid/ready handshake: every pin is a plain level that is sampled on each clock.

Top module: `hbridge_ctrl`

## Requirements
- R1: While `sleep_n` is low, all four gate enables are 0 in the following cycle, whatever the other inputs are.
- R2: With DRIVE_MODE=0, {ctl_a,ctl_b}=00 turns all gates off (both legs float). 01 turns on `gate_ls1` and `gate_hs2` (leg 1 low, leg 2 high). 10 turns on `gate_hs1` and `gate_ls2` (leg 1 high, leg 2 low).
- R3: With DRIVE_MODE=0, {ctl_a,ctl_b}=11 turns on only `gate_ls1` and `gate_ls2` (brake).
- R4: With DRIVE_MODE=1, `ctl_a` is the direction and `ctl_b` is the enable. ctl_b=0 turns on only both low-side gates. ctl_b=1 with ctl_a=1 turns on `gate_ls1` and `gate_hs2`. ctl_b=1 with ctl_a=0 turns on `gate_hs1` and `gate_ls2`.
- R5: While `uv_flag` is 1, all gates are 0 in the following cycle. Normal mapping returns in the cycle after the flag clears.
- R6: Any bit of `oc_flag` (bit 0 hs1, bit 1 ls1, bit 2 hs2, bit 3 ls2) triggers a shutdown only once some bit has been seen for DEGLITCH_CYC+1 consecutive cycles. A cycle with no bit set restarts the count.
- R7: After a shutdown, all gates stay 0 for exactly RETRY_CYC cycles, and `oc_flag` is ignored during that time. The normal mapping then resumes by itself.
- R8: `fault_retry` is 1 exactly in the cycles of the retry wait. It rises in the same cycle that the gates drop for the fault.
- R9: The high-side and low-side gates of the same leg are never 1 together.
- R10: Gate outputs are registered. A change on any input shows up at the gates one clock edge later and not before.
- R11: A cycle with `sleep_n` low clears any partial deglitch count and ends any retry wait. The bridge wakes in the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_n | input | 1 | Active-low sleep; low forces coast |
| ctl_a | input | 1 | Leg-1 input (mode 0) or direction (mode 1) |
| ctl_b | input | 1 | Leg-2 input (mode 0) or enable (mode 1) |
| uv_flag | input | 1 | Supply undervoltage flag |
| oc_flag | input | 4 | Per-switch overcurrent flags {ls2,hs2,ls1,hs1} |
| gate_hs1 | output | 1 | Leg 1 high-side enable |
| gate_ls1 | output | 1 | Leg 1 low-side enable |
| gate_hs2 | output | 1 | Leg 2 high-side enable |
| gate_ls2 | output | 1 | Leg 2 low-side enable |
| fault_retry | output | 1 | High during the overcurrent retry wait |

## Verification
The bench builds two copies side by side from the same stimulus. One uses DRIVE_MODE=0 and the other DRIVE_MODE=1, so both mappings run against one shared fault path. Both copies use DEGLITCH_CYC=3 and RETRY_CYC=5. These short windows let overcurrent bursts of two to five cycles fall just short of the trip point or just past it. They also let the bench put sleep pulses inside a deglitch count and inside a retry wait, and cycle through many full fault-and-restart rounds in a random run.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    FS_RUN   = 2'd0,
    FS_DGL   = 2'd1,
    FS_RETRY = 2'd2
  } fault_st_e;

  typedef struct packed {
    logic hs1;
    logic ls1;
    logic hs2;
    logic ls2;
  } gates_t;

  localparam gates_t GATES_OFF = '{hs1: 1'b0, ls1: 1'b0, hs2: 1'b0, ls2: 1'b0};

endpackage

// File: rtl/hb_drive_map.sv
module hb_drive_map
  import hb_pkg::*;
#(
  parameter int DRIVE_MODE = 0
) (
  input  logic   ctl_a,
  input  logic   ctl_b,
  output gates_t map_o
);

  generate
    if (DRIVE_MODE == 0) begin : g_two_input
      always_comb begin
        map_o = GATES_OFF;
        unique case ({ctl_a, ctl_b})
          2'b00: map_o = GATES_OFF;
          2'b01: begin map_o.ls1 = 1'b1; map_o.hs2 = 1'b1; end
          2'b10: begin map_o.hs1 = 1'b1; map_o.ls2 = 1'b1; end
          default: begin map_o.ls1 = 1'b1; map_o.ls2 = 1'b1; end
        endcase
      end
    end else begin : g_dir_enable
      always_comb begin
        map_o = GATES_OFF;
        if (!ctl_b) begin
          map_o.ls1 = 1'b1;
          map_o.ls2 = 1'b1;
        end else if (ctl_a) begin
          map_o.ls1 = 1'b1;
          map_o.hs2 = 1'b1;
        end else begin
          map_o.hs1 = 1'b1;
          map_o.ls2 = 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/hb_fault_fsm.sv
module hb_fault_fsm
  import hb_pkg::*;
#(
  parameter int DEGLITCH_CYC = 3,
  parameter int RETRY_CYC    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic oc_any,
  output logic retry_next,
  output logic retry_q
);

  localparam int MAXC = (DEGLITCH_CYC > RETRY_CYC) ? DEGLITCH_CYC : RETRY_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DGL_LAST = CW'(DEGLITCH_CYC);
  localparam logic [CW-1:0] RTY_LAST = CW'(RETRY_CYC - 1);

  fault_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!sleep_n) begin
      st_d  = FS_RUN;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        FS_RUN: if (oc_any) begin
          st_d  = FS_DGL;
          cnt_d = CW'(1);
        end
        FS_DGL: begin
          if (!oc_any) begin
            st_d  = FS_RUN;
            cnt_d = '0;
          end else if (cnt_q == DGL_LAST) begin
            st_d  = FS_RETRY;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == RTY_LAST) begin
            st_d  = FS_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= FS_RUN;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign retry_next = (st_d == FS_RETRY);
  assign retry_q    = (st_q == FS_RETRY);

  // R6
  run_no_direct_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_RUN) |=> (st_q != FS_RETRY));

  // R6
  trip_needs_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_DGL && !oc_any && sleep_n) |=> (st_q == FS_RUN));

  // R11
  sleep_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (st_q == FS_RUN && cnt_q == '0));

  // R7
  retry_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_RETRY) |-> (cnt_q <= RTY_LAST));

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int DRIVE_MODE   = 0,
  parameter int DEGLITCH_CYC = 3,
  parameter int RETRY_CYC    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       ctl_a,
  input  logic       ctl_b,
  input  logic       uv_flag,
  input  logic [3:0] oc_flag,
  output logic       gate_hs1,
  output logic       gate_ls1,
  output logic       gate_hs2,
  output logic       gate_ls2,
  output logic       fault_retry
);

  gates_t map_w, gates_q;
  logic   retry_next_w;
  logic   drive_ok;

  hb_drive_map #(.DRIVE_MODE(DRIVE_MODE)) u_map (
    .ctl_a (ctl_a),
    .ctl_b (ctl_b),
    .map_o (map_w)
  );

  hb_fault_fsm #(
    .DEGLITCH_CYC (DEGLITCH_CYC),
    .RETRY_CYC    (RETRY_CYC)
  ) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_n    (sleep_n),
    .oc_any     (|oc_flag),
    .retry_next (retry_next_w),
    .retry_q    (fault_retry)
  );

  assign drive_ok = sleep_n && !uv_flag && !retry_next_w;

  always_ff @(posedge clk) begin
    if (!rst_n) gates_q <= GATES_OFF;
    else        gates_q <= drive_ok ? map_w : GATES_OFF;
  end

  assign gate_hs1 = gates_q.hs1;
  assign gate_ls1 = gates_q.ls1;
  assign gate_hs2 = gates_q.hs2;
  assign gate_ls2 = gates_q.ls2;

  // R9
  leg1_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs1 && gate_ls1));

  // R9
  leg2_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs2 && gate_ls2));

  // R1
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !(gate_hs1 || gate_ls1 || gate_hs2 || gate_ls2));

  // R5
  uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> !(gate_hs1 || gate_ls1 || gate_hs2 || gate_ls2));

  // R8
  retry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_retry |-> !(gate_hs1 || gate_ls1 || gate_hs2 || gate_ls2));

endmodule

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;

  localparam int DGL = 3;
  localparam int RTY = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_n = 1'b1, ctl_a = 1'b0, ctl_b = 1'b0, uv_flag = 1'b0;
  logic [3:0] oc_flag = 4'h0;
  logic [3:0] g0, g1;
  logic f0, f1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hbridge_ctrl #(.DRIVE_MODE(0), .DEGLITCH_CYC(DGL), .RETRY_CYC(RTY)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .uv_flag(uv_flag), .oc_flag(oc_flag),
    .gate_hs1(g0[3]), .gate_ls1(g0[2]), .gate_hs2(g0[1]), .gate_ls2(g0[0]),
    .fault_retry(f0));

  hbridge_ctrl #(.DRIVE_MODE(1), .DEGLITCH_CYC(DGL), .RETRY_CYC(RTY)) u_dut_pe (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .uv_flag(uv_flag), .oc_flag(oc_flag),
    .gate_hs1(g1[3]), .gate_ls1(g1[2]), .gate_hs2(g1[1]), .gate_ls2(g1[0]),
    .fault_retry(f1));

  // expected order {hs1,ls1,hs2,ls2}
  function automatic logic [3:0] map_two(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 4'b0000;
      2'b01:   return 4'b0110;
      2'b10:   return 4'b1001;
      default: return 4'b0101;
    endcase
  endfunction

  function automatic logic [3:0] map_pe(input logic ph, input logic en);
    if (!en) return 4'b0101;
    return ph ? 4'b0110 : 4'b1001;
  endfunction

  // behavioural reference model
  int oc_run = 0;
  int retry_left = 0;
  logic [3:0] exp0 = 4'h0, exp1 = 4'h0;
  logic exp_f = 1'b0;
  string tag = "R10";

  always @(posedge clk) begin
    if (!rst_n) begin
      oc_run = 0; retry_left = 0; exp0 = 4'h0; exp1 = 4'h0; exp_f = 1'b0; tag = "R10";
    end else begin
      if (!sleep_n) begin
        oc_run = 0; retry_left = 0;
      end else if (retry_left > 0) begin
        retry_left = retry_left - 1;
      end else if (oc_flag != 4'h0) begin
        oc_run = oc_run + 1;
        if (oc_run > DGL) begin retry_left = RTY; oc_run = 0; end
      end else begin
        oc_run = 0;
      end
      exp_f = (retry_left > 0);
      if (!sleep_n)            tag = "R1";
      else if (uv_flag)        tag = "R5";
      else if (exp_f)          tag = "R7";
      else if (oc_run > 0)     tag = "R6";
      else if (ctl_a && ctl_b) tag = "R3";
      else                     tag = "R2";
      if (sleep_n && !uv_flag && !exp_f) begin
        exp0 = map_two(ctl_a, ctl_b);
        exp1 = map_pe(ctl_a, ctl_b);
      end else begin
        exp0 = 4'h0; exp1 = 4'h0;
      end
    end
  end

  task automatic check_outs(input string t);
    checks++;
    if (g0 !== exp0) begin
      errors++;
      $display("FAIL %s mode0 gates actual %b expected %b", t, g0, exp0);
    end
    checks++;
    if (g1 !== exp1) begin
      errors++;
      $display("FAIL %s mode1 gates actual %b expected %b",
               (t == "R2" || t == "R3") ? "R4" : t, g1, exp1);
    end
    checks++;
    if (f0 !== exp_f || f1 !== exp_f) begin
      errors++;
      $display("FAIL R8 fault actual %b/%b expected %b", f0, f1, exp_f);
    end
    checks++;
    if ((g0[3] && g0[2]) || (g0[1] && g0[0]) || (g1[3] && g1[2]) || (g1[1] && g1[0])) begin
      errors++;
      $display("FAIL R9 leg overlap actual %b/%b expected no overlap", g0, g1);
    end
  endtask

  // one cycle: compare at negedge, drive new inputs, confirm no early change
  task automatic step(input logic s, input logic a, input logic b,
                      input logic u, input logic [3:0] oc);
    logic [3:0] h0, h1;
    @(negedge clk);
    check_outs(tag);
    h0 = g0; h1 = g1;
    sleep_n = s; ctl_a = a; ctl_b = b; uv_flag = u; oc_flag = oc;
    #1;
    checks++;
    if (g0 !== h0 || g1 !== h1) begin
      errors++;
      $display("FAIL R10 gates moved before edge actual %b/%b expected %b/%b", g0, g1, h0, h1);
    end
  endtask

  task automatic oc_burst(input int len, input logic [3:0] bits, input int gap);
    for (int i = 0; i < len; i++) step(1, 1, 0, 0, bits);
    for (int i = 0; i < gap; i++) step(1, 1, 0, 0, 4'h0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    checks++;
    if (g0 !== 4'h0 || g1 !== 4'h0 || f0 !== 1'b0 || f1 !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset outputs actual %b/%b expected 0000", g0, g1);
    end
    rst_n = 1'b1;

    // R2 R3 R4: every input pair, normal operation
    for (int k = 0; k < 4; k++) begin
      step(1, k[1], k[0], 0, 4'h0);
      step(1, k[1], k[0], 0, 4'h0);
    end
    // R1: sleep overrides every input pair
    for (int k = 0; k < 4; k++) step(0, k[1], k[0], 0, 4'h0);
    step(1, 1, 1, 0, 4'h0);
    // R5: undervoltage and immediate resume
    for (int k = 0; k < 4; k++) step(1, k[1], k[0], 1, 4'h0);
    step(1, 0, 1, 0, 4'h0);
    step(1, 0, 1, 0, 4'h0);

    // R6: bursts just below and at the trip length, each switch flag
    oc_burst(DGL, 4'b0001, 2);
    oc_burst(DGL, 4'b1000, 1);
    oc_burst(DGL + 1, 4'b0010, RTY + 3);   // R7: trip then auto restart
    oc_burst(DGL + 1, 4'b0100, 1);
    // R7: flags during retry are ignored
    for (int i = 0; i < RTY + 2; i++) step(1, 0, 1, 0, 4'b1111);
    for (int i = 0; i < RTY + 2; i++) step(1, 0, 1, 0, 4'h0);

    // R11: sleep mid-deglitch restarts the count
    oc_burst(DGL, 4'b0001, 0);
    step(0, 1, 0, 0, 4'b0001);
    oc_burst(DGL, 4'b0001, 2);
    // R11: sleep during retry ends it, wake in run
    oc_burst(DGL + 1, 4'b0001, 1);
    step(0, 1, 0, 0, 4'h0);
    step(1, 1, 0, 0, 4'h0);
    step(1, 1, 0, 0, 4'h0);

    // mixed random run with held overcurrent bursts
    begin
      int hold = 0;
      logic [3:0] ocv = 4'h0;
      for (int i = 0; i < 3000; i++) begin
        if (hold == 0) begin
          hold = $urandom_range(1, 7);
          ocv = ($urandom_range(0, 2) == 0) ? 4'(1 << $urandom_range(0, 3)) : 4'h0;
        end
        hold--;
        step(($urandom_range(0, 15) != 0), 1'($urandom), 1'($urandom),
             ($urandom_range(0, 15) == 0), ocv);
      end
    end
    step(1, 0, 0, 0, 4'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule